// File: doc/BRIEF.md
# Three-wire configuration register slave

This block is the receive-only serial configuration port of a radio transceiver. A host drives an active-low enable, a serial clock and a serial data line. While the enable is low, each rising edge of the serial clock moves one data bit, most significant first, into a shift register. When the enable returns high, the lowest sixteen shifted bits become the active control word. The block then raises a one-cycle update strobe so that downstream logic can restart its synthesizer settling timers.

All three serial inputs are asynchronous to the fast system clock. Each passes through a synchroniser, and the edges are detected in the system clock domain. The frame length is never checked: surplus leading bits fall off the top of the shift register. A frame of 25 or more bits whose top nine bits carry a fixed prefix also switches on receive clock recovery. The active word is decoded into fields: transmit or receive selection, PA ramp level, deviation scaling, reference select, main counter and swallow count.

Top module: `cfg3w_slave`

## Requirements
- R1: After reset, every decoded output is zero, except `main_count` (86), `dev_pct` (60) and `ramp_mv` (1300). `clk_rec_en` and `upd_stb` are low.
- R2: Data is taken only on rising edges of `ser_clk` while `ser_en_n` is low. Serial clock pulses while the enable is high raise no strobe and change no output.
- R3: The outputs keep their previous values for the whole of an enable-low period and change only with the update strobe.
- R4: Each rising edge of `ser_en_n` produces exactly one `upd_stb` pulse, one system clock wide. The new field values are visible in the same cycle as the pulse.
- R5: Bits are shifted in most significant first, and the frame length is not checked. When more than 16 bits arrive, only the last 16 form the active word.
- R6: Fields of the active word: bits 13:12 give `ramp_code`, bits 11:9 give `dev_code`, bit 8 gives `tx_sel` (1 = transmit, 0 = receive), bit 7 gives `ref_sel`, bits 6:5 give `mc_code` and bits 4:0 give `swallow`.
- R7: `main_count` is 86, 87, 88 or 89 for `mc_code` 0, 1, 2 or 3.
- R8: `dev_pct` is 60 + 10 × `dev_code`, covering 60 to 130. `ramp_mv` is 1300, 1350, 1400 or 1750 for `ramp_code` 0 to 3.
- R9: `clk_rec_en` is set at the update only if at least 25 bits arrived in that enable-low period and bits 24:16 of the last 25 equal 101000000. Frames with more than 25 bits qualify when their last 25 bits match.
- R10: `clk_rec_en` is cleared at any update whose frame has fewer than 25 bits or a wrong prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_en_n | input | 1 | Active-low frame enable; its rising edge commits the frame |
| upd_stb | output | 1 | One-cycle pulse when a new word becomes active |
| tx_sel | output | 1 | 1 = transmit, 0 = receive |
| ramp_code | output | 2 | PA ramp level code |
| ramp_mv | output | 11 | PA ramp level in millivolts |
| dev_code | output | 3 | Deviation scaling code |
| dev_pct | output | 8 | Deviation scaling in percent |
| ref_sel | output | 1 | Reference clock select |
| mc_code | output | 2 | Main counter code |
| main_count | output | 7 | Main counter value, 86 to 89 |
| swallow | output | 5 | Swallow count, 0 to 31 |
| clk_rec_en | output | 1 | Receive clock recovery enable |

## Verification
Four properties are checked on every cycle:
- the update strobe never lasts more than one cycle;
- the active word and the recovery flag move only with that strobe;
- serial clock edges seen while the enable is high leave the shift register untouched;
- the deviation percentage stays on its ten-percent grid.

Other behaviours are visible only through the bench's frame sequences. These are the most-significant-first ordering, the discarding of surplus leading bits, and the field and value decoding. They also include the qualification of clock recovery by bit count and prefix, for 24-, 25- and 29-bit frames.

// File: rtl/cfg3w_slave.sv
module cfg3w_slave #(
  parameter int SYNC_STAGES = 2,
  parameter int WORD_BITS   = 16,
  parameter int EXT_BITS    = 25,
  parameter logic [EXT_BITS-WORD_BITS-1:0] CR_PREFIX = 9'b101000000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        ser_clk,
  input  logic        ser_dat,
  input  logic        ser_en_n,
  output logic        upd_stb,
  output logic        tx_sel,
  output logic [1:0]  ramp_code,
  output logic [10:0] ramp_mv,
  output logic [2:0]  dev_code,
  output logic [7:0]  dev_pct,
  output logic        ref_sel,
  output logic [1:0]  mc_code,
  output logic [6:0]  main_count,
  output logic [4:0]  swallow,
  output logic        clk_rec_en
);
  localparam int CNT_W = $clog2(EXT_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(EXT_BITS);

  logic [SYNC_STAGES-1:0] ck_sy, dt_sy, en_sy;
  logic ck_d, en_d;
  logic [EXT_BITS-1:0]  shreg;
  logic [CNT_W-1:0]     cnt;
  logic [WORD_BITS-1:0] act;

  wire ck_s    = ck_sy[SYNC_STAGES-1];
  wire dt_s    = dt_sy[SYNC_STAGES-1];
  wire en_s    = en_sy[SYNC_STAGES-1];
  wire ck_rise = ck_s & ~ck_d;
  wire en_fall = ~en_s & en_d;
  wire en_rise = en_s & ~en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sy <= '0;
      dt_sy <= '0;
      en_sy <= '1;
      ck_d  <= 1'b0;
      en_d  <= 1'b1;
    end else begin
      ck_sy <= {ck_sy[SYNC_STAGES-2:0], ser_clk};
      dt_sy <= {dt_sy[SYNC_STAGES-2:0], ser_dat};
      en_sy <= {en_sy[SYNC_STAGES-2:0], ser_en_n};
      ck_d  <= ck_s;
      en_d  <= en_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg      <= '0;
      cnt        <= '0;
      act        <= '0;
      clk_rec_en <= 1'b0;
      upd_stb    <= 1'b0;
    end else begin
      upd_stb <= 1'b0;
      if (en_fall) begin
        cnt <= '0;
      end else if (ck_rise && !en_s) begin
        shreg <= {shreg[EXT_BITS-2:0], dt_s};
        if (cnt != CNT_MAX) cnt <= cnt + 1'b1;
      end
      if (en_rise) begin
        act        <= shreg[WORD_BITS-1:0];
        clk_rec_en <= (cnt == CNT_MAX) && (shreg[EXT_BITS-1:WORD_BITS] == CR_PREFIX);
        upd_stb    <= 1'b1;
      end
    end
  end

  assign ramp_code  = act[13:12];
  assign dev_code   = act[11:9];
  assign tx_sel     = act[8];
  assign ref_sel    = act[7];
  assign mc_code    = act[6:5];
  assign swallow    = act[4:0];
  assign main_count = 7'd86 + {5'd0, mc_code};
  assign dev_pct    = 8'd60 + 8'd10 * {5'd0, dev_code};

  always_comb begin
    case (ramp_code)
      2'd0:    ramp_mv = 11'd1300;
      2'd1:    ramp_mv = 11'd1350;
      2'd2:    ramp_mv = 11'd1400;
      default: ramp_mv = 11'd1750;
    endcase
  end

  // R4
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd_stb |=> !upd_stb);

  // R3
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_stb |-> ($stable(act) && $stable(clk_rec_en)));

  // R2
  idle_clock_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ck_rise && en_s) |=> $stable(shreg));

  // R8
  always_comb begin
    dev_grid_chk: assert (dev_pct >= 8'd60 && dev_pct <= 8'd130 && (dev_pct % 8'd10) == 8'd0);
  end
endmodule

// File: tb/cfg3w_slave_tb_top.sv
`timescale 1ns/1ps
module cfg3w_slave_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en_n = 1'b1;
  logic upd_stb, tx_sel, ref_sel, clk_rec_en;
  logic [1:0] ramp_code, mc_code;
  logic [10:0] ramp_mv;
  logic [2:0] dev_code;
  logic [7:0] dev_pct;
  logic [6:0] main_count;
  logic [4:0] swallow;

  always #2.5 clk = ~clk;

  cfg3w_slave dut_i (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en_n(ser_en_n),
    .upd_stb(upd_stb), .tx_sel(tx_sel), .ramp_code(ramp_code), .ramp_mv(ramp_mv),
    .dev_code(dev_code), .dev_pct(dev_pct), .ref_sel(ref_sel), .mc_code(mc_code),
    .main_count(main_count), .swallow(swallow), .clk_rec_en(clk_rec_en));

  typedef struct packed {
    logic tx; logic [1:0] rc; logic [10:0] mv; logic [2:0] dc; logic [7:0] pct;
    logic rf; logic [1:0] mc; logic [6:0] mcnt; logic [4:0] sw; logic rec;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int n_chk = 0, n_fail = 0, n_stb = 0;

  task automatic chk(input bit ok, input string req, input int act_v, input int exp_v);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act_v, exp_v);
    end
  endtask

  function automatic exp_t model(input logic [31:0] bits, input int n);
    exp_t e;
    logic [15:0] w = bits[15:0];
    e.rc = w[13:12]; e.dc = w[11:9]; e.tx = w[8]; e.rf = w[7]; e.mc = w[6:5]; e.sw = w[4:0];
    e.mcnt = 7'(86 + int'(e.mc));
    e.pct  = 8'(60 + 10 * int'(e.dc));
    case (e.rc)
      2'd0: e.mv = 11'd1300; 2'd1: e.mv = 11'd1350;
      2'd2: e.mv = 11'd1400; default: e.mv = 11'd1750;
    endcase
    e.rec = (n >= 25) && (bits[24:16] == 9'b101000000);
    return e;
  endfunction

  task automatic compare_all(input exp_t e, input string tag);
    chk(tx_sel == e.tx, {"R6 tx_sel ", tag}, tx_sel, e.tx);
    chk(ramp_code == e.rc, {"R6 ramp_code ", tag}, ramp_code, e.rc);
    chk(dev_code == e.dc, {"R6 dev_code ", tag}, dev_code, e.dc);
    chk(ref_sel == e.rf, {"R6 ref_sel ", tag}, ref_sel, e.rf);
    chk(mc_code == e.mc, {"R6 mc_code ", tag}, mc_code, e.mc);
    chk(swallow == e.sw, {"R5 R6 swallow ", tag}, swallow, e.sw);
    chk(main_count == e.mcnt, {"R7 main_count ", tag}, main_count, e.mcnt);
    chk(dev_pct == e.pct, {"R8 dev_pct ", tag}, dev_pct, e.pct);
    chk(ramp_mv == e.mv, {"R8 ramp_mv ", tag}, ramp_mv, e.mv);
    chk(clk_rec_en == e.rec, {"R9 R10 clk_rec_en ", tag}, clk_rec_en, e.rec);
  endtask

  always @(negedge clk) begin
    if (rst_n && upd_stb) begin
      n_stb++;
      if (q.size() == 0) chk(1'b0, "R4 unexpected strobe", 1, 0);
      else begin
        cur = q.pop_front();
        compare_all(cur, "update");
      end
    end
  end

  task automatic send(input logic [31:0] bits, input int n);
    @(negedge clk) ser_en_n = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      ser_dat = bits[i];
      repeat (4) @(negedge clk);
      ser_clk = 1'b1;
      repeat (4) @(negedge clk);
      ser_clk = 1'b0;
      if (i == n / 2) begin
        repeat (6) @(negedge clk);
        compare_all(cur, "R3 hold mid-frame");
      end
    end
    repeat (4) @(negedge clk);
    q.push_back(model(bits, n));
    ser_en_n = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    #400000;
    chk(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    int stb_before;
    repeat (5) @(negedge clk);
    // R1 reset state
    cur = model(32'd0, 16);
    compare_all(cur, "R1 reset");
    chk(upd_stb == 1'b0, "R1 strobe low in reset", upd_stb, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (5) @(negedge clk);
    compare_all(cur, "R1 after reset");

    send(32'h0000_6BAD, 16);       // tx, ramp2, dev5, ref1, mc1, sw13
    send(32'h0000_3E7F, 16);       // rx, ramp3, dev7, ref0, mc3, sw31
    // R5 surplus leading bits
    send(32'h000F_5341, 20);
    // R9 recovery frame
    send({7'd0, 9'b101000000, 16'h00A7}, 25);
    // R10 24 bits: too few
    send({8'd0, 8'b01000000, 16'h4123}, 24);
    // R10 wrong prefix
    send({7'd0, 9'b101000001, 16'h00A7}, 25);
    // R9 R5 29 bits, last 25 match
    send({3'd0, 4'b1101, 9'b101000000, 16'h1E45}, 29);
    // R10 plain 16-bit frame clears recovery
    send(32'h0000_4262, 16);
    // R7 R8 sweep
    for (int k = 0; k < 8; k++)
      send({16'd0, 2'b01, 2'(k), 3'(k), 1'(k), 1'(k >> 1), 2'(k + 1), 5'(k * 3)}, 16);

    // R2 clock pulses with enable high
    stb_before = n_stb;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk) ser_dat = ~ser_dat;
      repeat (3) @(negedge clk) ser_clk = 1'b1;
      repeat (3) @(negedge clk) ser_clk = 1'b0;
    end
    repeat (10) @(negedge clk);
    chk(n_stb == stb_before, "R2 no strobe with enable high", n_stb, stb_before);
    compare_all(cur, "R2 idle clocks");

    // R4 one strobe per enable rise
    chk(n_stb == 16, "R4 strobe count", n_stb, 16);
    chk(q.size() == 0, "R4 pending expectations", q.size(), 0);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule